// File: doc/BRIEF.md
# Pointer-Stepped Bit Buffer

This block is a small bit-manipulation store of sixteen bits, kept as four 4-bit words. Software sees it two ways. A nibble-wide bus port reads or writes one whole word by its 2-bit word address. A single-bit port works on the one bit chosen by a 4-bit pointer. Commands can set that bit, clear it, test it or load the pointer. Other commands step the pointer up or down by one. Code that walks a long bit string can therefore touch consecutive bits without working out any addresses.

Stepping past either end of the range raises a one-cycle skip flag, and loop code uses this flag as its exit condition. A test command raises the same flag when the selected bit is 1. The upper two pointer bits select the word and the lower two select the bit inside that word, so pointer value 0 is bit 0 of word 0 and value 15 is bit 3 of word 3.

The pointer logic has four step states: STEP_HOLD, STEP_UP, STEP_DOWN and STEP_LOAD. The op code moves it between them each cycle: increment goes to STEP_UP, decrement to STEP_DOWN, load to STEP_LOAD, and every other code to STEP_HOLD. An STEP_UP from 15 lands on 0, and an STEP_DOWN from 0 lands on 15. The 3-bit op codes are NOP=0, SET=1, CLR=2, INC=3, DEC=4, LOAD=5, TEST=6. Code 7 acts as NOP.

Top module: `bsb_top`

## Requirements
- R1: After reset all four words read 0, the pointer is 0 and skip_o is 0.
- R2: A bus write (bus_we_i=1) stores bus_wdata_i into word bus_addr_i at the clock edge. bus_rdata_o always shows the word at bus_addr_i.
- R3: The pointer maps to bit number ptr: word ptr[3:2], bit ptr[1:0]. bit_o always shows that stored bit.
- R4: SET (op 1) writes 1 to the selected bit and leaves the other 15 bits unchanged.
- R5: CLR (op 2) writes 0 to the selected bit and leaves the other 15 bits unchanged.
- R6: INC (op 3) makes the pointer ptr+1 modulo 16. skip_o is 1 in the following cycle exactly when the pointer went from 15 to 0.
- R7: DEC (op 4) makes the pointer ptr-1 modulo 16. skip_o is 1 in the following cycle exactly when the pointer went from 0 to 15.
- R8: LOAD (op 5) copies ptr_wdata_i into the pointer.
- R9: TEST (op 6) sets skip_o in the following cycle to the value the selected bit held before the edge. The buffer and the pointer do not change.
- R10: If a bus write and a SET or CLR hit the same word in one cycle, the word takes the bus data. If they hit different words, both writes take effect.
- R11: NOP (op 0) and the unused code 7 leave the pointer and the buffer unchanged and give skip_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Bit/pointer command |
| ptr_wdata_i | input | 4 | Pointer value for LOAD |
| bus_we_i | input | 1 | Nibble write enable |
| bus_addr_i | input | 2 | Word address of the bus port |
| bus_wdata_i | input | 4 | Nibble write data |
| bus_rdata_o | output | 4 | Word at bus_addr_i |
| bit_o | output | 1 | Bit selected by the pointer |
| ptr_o | output | 4 | Current pointer |
| skip_o | output | 1 | Wrap or test-true flag for the previous command |

## Verification
A wrong pointer state shows on ptr_o one cycle after the command that caused it. It also changes which bit appears on bit_o, so the bench follows both after every command. A stored bit that is wrong, or one that was disturbed by a neighbouring write, shows on bus_rdata_o as soon as its word is addressed. It also shows on bit_o as soon as the pointer reaches it. The bench therefore reads back whole words after bit writes and walks the pointer across all sixteen bits. Wrap and test errors show only in the single skip_o cycle after the command, so every command's skip value is compared in that cycle.

// File: rtl/bsb_pkg.sv
package bsb_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_SET  = 3'd1,
        OP_CLR  = 3'd2,
        OP_INC  = 3'd3,
        OP_DEC  = 3'd4,
        OP_LOAD = 3'd5,
        OP_TEST = 3'd6,
        OP_RSVD = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_LOAD = 2'd3
    } step_e;

endpackage

// File: rtl/bsb_ptr.sv
module bsb_ptr
    import bsb_pkg::*;
#(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step_i,
    input  logic [PTR_W-1:0] load_val_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             wrap_o
);

    localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};
    localparam logic [PTR_W-1:0] PTR_MIN = '0;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_d;

    always_comb begin
        ptr_d  = ptr_q;
        wrap_o = 1'b0;
        unique case (step_i)
            STEP_HOLD: ptr_d = ptr_q;
            STEP_UP: begin
                ptr_d  = ptr_q + 1'b1;
                wrap_o = (ptr_q == PTR_MAX);
            end
            STEP_DOWN: begin
                ptr_d  = ptr_q - 1'b1;
                wrap_o = (ptr_q == PTR_MIN);
            end
            STEP_LOAD: ptr_d = load_val_i;
            default:   ptr_d = ptr_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    // R6
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_UP) |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

    // R7
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_DOWN) |=> (ptr_q == PTR_W'($past(ptr_q) - 1'b1)));

    // R8
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i == STEP_LOAD) |=> (ptr_q == $past(load_val_i)));

endmodule

// File: rtl/bsb_store.sv
module bsb_store #(
    parameter int WORD_W    = 4,
    parameter int NUM_WORDS = 4,
    localparam int PTR_W  = $clog2(WORD_W * NUM_WORDS),
    localparam int WSEL_W = $clog2(NUM_WORDS),
    localparam int BSEL_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we_i,
    input  logic [WSEL_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    input  logic              bit_we_i,
    input  logic              bit_val_i,
    input  logic [PTR_W-1:0]  bit_idx_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              sel_bit_o
);

    logic [WORD_W-1:0] word_q [NUM_WORDS];
    logic [WSEL_W-1:0] wsel;
    logic [BSEL_W-1:0] bsel;
    logic              collide;

    assign wsel    = bit_idx_i[PTR_W-1:BSEL_W];
    assign bsel    = bit_idx_i[BSEL_W-1:0];
    assign collide = bus_we_i && (bus_addr_i == wsel);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) word_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (bus_we_i && (bus_addr_i == WSEL_W'(i)))
                    word_q[i] <= bus_wdata_i;
                else if (bit_we_i && (wsel == WSEL_W'(i)))
                    word_q[i][bsel] <= bit_val_i;
            end
        end
    end

    assign bus_rdata_o = word_q[bus_addr_i];
    assign sel_bit_o   = word_q[wsel][bsel];

    // R2
    bus_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we_i |=> (word_q[$past(bus_addr_i)] == $past(bus_wdata_i)));

    // R4 R5
    bit_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we_i && !collide) |=> (word_q[$past(wsel)][$past(bsel)] == $past(bit_val_i)));

    // R10
    bus_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_we_i && collide) |=> (word_q[$past(wsel)] == $past(bus_wdata_i)));

endmodule

// File: rtl/bsb_top.sv
module bsb_top
    import bsb_pkg::*;
#(
    parameter int WORD_W    = 4,
    parameter int NUM_WORDS = 4,
    localparam int PTR_W  = $clog2(WORD_W * NUM_WORDS),
    localparam int WSEL_W = $clog2(NUM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [PTR_W-1:0]  ptr_wdata_i,
    input  logic              bus_we_i,
    input  logic [WSEL_W-1:0] bus_addr_i,
    input  logic [WORD_W-1:0] bus_wdata_i,
    output logic [WORD_W-1:0] bus_rdata_o,
    output logic              bit_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              skip_o
);

    localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};

    op_e   op;
    step_e step;
    logic  bit_we;
    logic  bit_val;
    logic  test_req;
    logic  wrap;
    logic  sel_bit;
    logic  skip_q;

    assign op = op_e'(op_i);

    always_comb begin
        step     = STEP_HOLD;
        bit_we   = 1'b0;
        bit_val  = 1'b0;
        test_req = 1'b0;
        unique case (op)
            OP_SET:  begin bit_we = 1'b1; bit_val = 1'b1; end
            OP_CLR:  begin bit_we = 1'b1; bit_val = 1'b0; end
            OP_INC:  step = STEP_UP;
            OP_DEC:  step = STEP_DOWN;
            OP_LOAD: step = STEP_LOAD;
            OP_TEST: test_req = 1'b1;
            default: step = STEP_HOLD;
        endcase
    end

    bsb_ptr #(.PTR_W(PTR_W)) ptr_u (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .load_val_i (ptr_wdata_i),
        .ptr_o      (ptr_o),
        .wrap_o     (wrap)
    );

    bsb_store #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) store_u (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bit_we_i    (bit_we),
        .bit_val_i   (bit_val),
        .bit_idx_i   (ptr_o),
        .bus_rdata_o (bus_rdata_o),
        .sel_bit_o   (sel_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) skip_q <= 1'b0;
        else        skip_q <= wrap | (test_req & sel_bit);
    end

    assign skip_o = skip_q;
    assign bit_o  = sel_bit;

    // R6
    inc_wrap_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_INC && ptr_o == PTR_MAX) |=> (skip_o && ptr_o == '0));

    // R7
    dec_wrap_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DEC && ptr_o == '0) |=> (skip_o && ptr_o == PTR_MAX));

    // R9
    test_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TEST) |=> (skip_o == $past(bit_o) && $stable(ptr_o)));

    // R11
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NOP || op == OP_RSVD) |=> (!skip_o && $stable(ptr_o)));

endmodule

// File: tb/bsb_top_tb_top.sv
module bsb_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_i = 3'd0;
    logic [3:0] ptr_wdata_i = 4'd0;
    logic       bus_we_i = 1'b0;
    logic [1:0] bus_addr_i = 2'd0;
    logic [3:0] bus_wdata_i = 4'd0;
    logic [3:0] bus_rdata_o;
    logic       bit_o;
    logic [3:0] ptr_o;
    logic       skip_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [3:0] ptr;
        logic       skip;
        logic       bitv;
        logic [3:0] rdata;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic [15:0] m_bits = '0;
    logic [3:0]  m_ptr  = '0;

    always #10 clk = ~clk;

    bsb_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_i        (op_i),
        .ptr_wdata_i (ptr_wdata_i),
        .bus_we_i    (bus_we_i),
        .bus_addr_i  (bus_addr_i),
        .bus_wdata_i (bus_wdata_i),
        .bus_rdata_o (bus_rdata_o),
        .bit_o       (bit_o),
        .ptr_o       (ptr_o),
        .skip_o      (skip_o)
    );

    task automatic drive(input logic [2:0] op, input logic [3:0] ld,
                         input logic bwe, input logic [1:0] baddr,
                         input logic [3:0] bdata, input string tag);
        exp_t e;
        logic skip;
        @(negedge clk);
        op_i = op; ptr_wdata_i = ld; bus_we_i = bwe;
        bus_addr_i = baddr; bus_wdata_i = bdata;
        skip = 1'b0;
        case (op)
            3'd1, 3'd2: if (!(bwe && baddr == m_ptr[3:2])) m_bits[m_ptr] = (op == 3'd1);
            3'd3: begin skip = (m_ptr == 4'hF); m_ptr = m_ptr + 4'd1; end
            3'd4: begin skip = (m_ptr == 4'h0); m_ptr = m_ptr - 4'd1; end
            3'd5: m_ptr = ld;
            3'd6: skip = m_bits[m_ptr];
            default: ;
        endcase
        if (bwe) m_bits[baddr*4 +: 4] = bdata;
        e.ptr = m_ptr; e.skip = skip; e.bitv = m_bits[m_ptr];
        e.rdata = m_bits[baddr*4 +: 4]; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        op_i = 3'd0; bus_we_i = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (ptr_o !== e.ptr || skip_o !== e.skip || bit_o !== e.bitv || bus_rdata_o !== e.rdata) begin
                    errors++;
                    $display("FAIL %s: ptr/skip/bit/rdata actual %h/%b/%b/%h expected %h/%b/%b/%h",
                             e.tag, ptr_o, skip_o, bit_o, bus_rdata_o, e.ptr, e.skip, e.bitv, e.rdata);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_addr_i = 2'(a);
            #1;
            checks++;
            if (bus_rdata_o !== 4'h0 || ptr_o !== 4'h0 || skip_o !== 1'b0 || bit_o !== 1'b0) begin
                errors++;
                $display("FAIL R1: rdata/ptr/skip actual %h/%h/%b expected 0/0/0", bus_rdata_o, ptr_o, skip_o);
            end
        end
        // R2 nibble writes
        drive(3'd0, 4'd0, 1'b1, 2'd0, 4'hA, "R2");
        drive(3'd0, 4'd0, 1'b1, 2'd1, 4'h5, "R2");
        drive(3'd0, 4'd0, 1'b1, 2'd2, 4'hF, "R2");
        drive(3'd0, 4'd0, 1'b1, 2'd3, 4'h0, "R2");
        // R8 load, R3 mapping
        drive(3'd5, 4'd0, 1'b0, 2'd0, 4'h0, "R8");
        drive(3'd5, 4'd5, 1'b0, 2'd1, 4'h0, "R3");
        // R9 test
        drive(3'd5, 4'd0, 1'b0, 2'd0, 4'h0, "R8");
        drive(3'd6, 4'd0, 1'b0, 2'd0, 4'h0, "R9");
        drive(3'd5, 4'd1, 1'b0, 2'd0, 4'h0, "R8");
        drive(3'd6, 4'd0, 1'b0, 2'd0, 4'h0, "R9");
        // R4 set in word 3, R5 clear in word 2
        drive(3'd5, 4'd12, 1'b0, 2'd3, 4'h0, "R8");
        drive(3'd1, 4'd0, 1'b0, 2'd3, 4'h0, "R4");
        drive(3'd5, 4'd9, 1'b0, 2'd2, 4'h0, "R8");
        drive(3'd2, 4'd0, 1'b0, 2'd2, 4'h0, "R5");
        drive(3'd0, 4'd0, 1'b0, 2'd3, 4'h0, "R5");
        // R6 increment wrap
        drive(3'd5, 4'd15, 1'b0, 2'd0, 4'h0, "R8");
        drive(3'd3, 4'd0, 1'b0, 2'd0, 4'h0, "R6");
        drive(3'd3, 4'd0, 1'b0, 2'd0, 4'h0, "R6");
        // R7 decrement wrap
        drive(3'd5, 4'd0, 1'b0, 2'd0, 4'h0, "R8");
        drive(3'd4, 4'd0, 1'b0, 2'd0, 4'h0, "R7");
        drive(3'd4, 4'd0, 1'b0, 2'd0, 4'h0, "R7");
        // R10 same word: bus wins; different word: both apply
        drive(3'd5, 4'd4, 1'b0, 2'd1, 4'h0, "R8");
        drive(3'd1, 4'd0, 1'b1, 2'd1, 4'h0, "R10");
        drive(3'd5, 4'd8, 1'b0, 2'd0, 4'h0, "R8");
        drive(3'd2, 4'd0, 1'b1, 2'd0, 4'h3, "R10");
        drive(3'd0, 4'd0, 1'b0, 2'd2, 4'h0, "R10");
        // R11 nop and reserved code
        drive(3'd0, 4'd7, 1'b0, 2'd2, 4'h0, "R11");
        drive(3'd7, 4'd7, 1'b0, 2'd2, 4'h0, "R11");
        // R3 R4 R6 walk: set every odd bit, then read back all
        drive(3'd5, 4'd0, 1'b0, 2'd0, 4'h0, "R8");
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 1) drive(3'd1, 4'd0, 1'b0, 2'(i / 4), 4'h0, "R4");
            else            drive(3'd2, 4'd0, 1'b0, 2'(i / 4), 4'h0, "R5");
            drive(3'd3, 4'd0, 1'b0, 2'(i / 4), 4'h0, "R6");
        end
        for (int i = 0; i < 16; i++) begin
            drive(3'd4, 4'd0, 1'b0, 2'(i % 4), 4'h0, "R3");
            drive(3'd6, 4'd0, 1'b0, 2'(i % 4), 4'h0, "R9");
        end
        idle();
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule